// File: doc/BRIEF.md
# Crosspoint Pin Cell

One programmable pin slice of a signal-routing crosspoint. Four candidate data sources come in from the routing pool. A Gray-ordered 4:1 selector picks one of them under two dynamic select lines. The selected value can pass straight to the pin, or go through a storage element that is set up as an edge-triggered register or as a transparent latch. The storage element can also be moved to the input side, where it captures the sampled pin value and feeds the routing pool instead.

A static configuration word sets the following:
- which select pin drives each select line, and the polarity of each line;
- the source and polarity of the clock and the clock enable;
- the output-enable mode and its polarity;
- the storage mode and which path the storage element sits in;
- a fixed-level jumper mode;
- the final output polarity.

The raw selector output always goes to neighbouring cells so that they can cascade into wider selectors. An init indication from power-up control holds the pin driver off. The word is meant to change only while reset is asserted.

Top module: `xpt_pin_cell`

## Requirements
- R1: The 17-bit `cfg` word is laid out as follows.
  - bit 0: line S0 source (0 = `sel_a`, 1 = `sel_b`).
  - bit 1: line S1 source (0 = `sel_b`, 1 = `sel_a`).
  - bit 2: S0 invert. bit 3: S1 invert.
  - bit 4: clock source (0 = `gclk`, 1 = `rclk`). bit 5: clock invert.
  - bit 6: enable source (0 = `gce`, 1 = `rce`). bit 7: enable invert.
  - bits 9:8: OE mode (0 = off, 1 = on, 2 = `roe`, 3 = on). bit 10: `roe` invert.
  - bits 12:11: storage mode (0 = bypass, 1 = register, 2 = latch, 3 = bypass).
  - bit 13: input path. bit 14: fixed-level enable. bit 15: fixed level. bit 16: output invert.
- R2: With select lines {S1,S0}, the selector output is M0 for 00, M1 for 01, M2 for 11 and M3 for 10. M0 is `m_in[DW-1:0]` and Mk is the k-th DW-wide slice.
- R3: Each select line takes its source pin and polarity from `cfg`. Setting bits 0 and 1 swaps the two select pins.
- R4: In register mode the stored value takes the storage input on each rising edge of the effective clock (chosen source XOR clock invert) when the effective enable (chosen source XOR enable invert) is 1.
- R5: When the effective enable is 0, the stored value does not change, in both register mode and latch mode.
- R6: In latch mode the stored value follows the storage input while the effective clock and the effective enable are both 1, and holds otherwise.
- R7: In bypass mode the storage output equals the storage input combinationally.
- R8: In the output path (bit 13 = 0) the storage input is the selector output, `pin_out` comes from the storage output and `pool_out` equals `pin_in`. In the input path (bit 13 = 1) the storage input is `pin_in`, `pool_out` is the storage output and `pin_out` comes from the selector output.
- R9: When bit 14 is set, `pin_out` is bit 15 on every bit, regardless of output invert and of the data path, and the driver is enabled unless `init_hold` is high.
- R10: Outside fixed mode, `pin_out` is the path value XOR bit 16.
- R11: Outside fixed mode, `pin_oe` follows the OE mode: 0 gives off, 1 or 3 gives on, and 2 gives `roe` XOR bit 10.
- R12: `pin_oe` is 0 whenever `init_hold` is 1.
- R13: `rst_n` low clears the stored value to 0 asynchronously, in both register mode and latch mode.
- R14: `nbr_out` always equals the selector output, before storage and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | dedicated global clock |
| gce | input | 1 | global clock enable |
| rst_n | input | 1 | asynchronous reset of storage, active low |
| init_hold | input | 1 | power-up/init indication; forces driver off |
| cfg | input | 17 | static configuration word (layout in R1) |
| m_in | input | 4*DW | four selector data candidates, M0 in the low slice |
| sel_a | input | 1 | first routed select pin |
| sel_b | input | 1 | second routed select pin |
| rclk | input | 1 | routed clock |
| rce | input | 1 | routed clock enable |
| roe | input | 1 | routed output enable |
| pin_in | input | DW | sampled pin value |
| pin_out | output | DW | value presented to the pin driver |
| pin_oe | output | 1 | pin driver enable |
| nbr_out | output | DW | raw selector output for neighbouring cells |
| pool_out | output | DW | feedback into the routing pool |

## Verification
A corrupted stored value appears at `pin_out` in the output path, or at `pool_out` in the input path. It is visible at the first sample after the effective clock edge or latch window that wrote it, and it stays wrong until the next enabled capture. A select decode or source swap fault is combinational: it shows on `nbr_out` in the same cycle, independent of storage mode. Polarity, OE and fixed-level faults are also combinational, so they appear in the cycle the stimulus is applied.

// File: rtl/xpt_cell_pkg.sv
`timescale 1ns/1ps
package xpt_cell_pkg;
   localparam int CFG_W = 17;
   localparam int NSRC  = 4;

   typedef enum logic [1:0] {
      OE_OFF    = 2'd0,
      OE_ON     = 2'd1,
      OE_PIN    = 2'd2,
      OE_ON_ALT = 2'd3
   } oe_mode_e;

   typedef enum logic [1:0] {
      ST_THRU     = 2'd0,
      ST_REG      = 2'd1,
      ST_LATCH    = 2'd2,
      ST_THRU_ALT = 2'd3
   } st_mode_e;

   // Packed MSB first; bit 0 is s0_src.
   typedef struct packed {
      logic     out_inv;   // 16
      logic     fix_val;   // 15
      logic     fix_en;    // 14
      logic     path_b;    // 13
      st_mode_e st;        // 12:11
      logic     oe_inv;    // 10
      oe_mode_e oe;        // 9:8
      logic     ce_inv;    // 7
      logic     ce_src;    // 6
      logic     clk_inv;   // 5
      logic     clk_src;   // 4
      logic     s1_inv;    // 3
      logic     s0_inv;    // 2
      logic     s1_src;    // 1
      logic     s0_src;    // 0
   } cell_cfg_t;
endpackage

// File: rtl/xpt_sel_mux.sv
`timescale 1ns/1ps
module xpt_sel_mux
   import xpt_cell_pkg::*;
#(
   parameter int DW = 1
) (
   input  logic [NSRC*DW-1:0] m_in,
   input  logic               sel_a,
   input  logic               sel_b,
   input  logic               s0_src,
   input  logic               s1_src,
   input  logic               s0_inv,
   input  logic               s1_inv,
   output logic [DW-1:0]      y
);
   logic [DW-1:0] cand [NSRC];
   logic          s0, s1;

   for (genvar k = 0; k < NSRC; k++) begin : g_slice
      assign cand[k] = m_in[k*DW +: DW];
   end

   // line S0 defaults to sel_a, line S1 defaults to sel_b (R3)
   assign s0 = (s0_src ? sel_b : sel_a) ^ s0_inv;
   assign s1 = (s1_src ? sel_a : sel_b) ^ s1_inv;

   // Gray order: 00,01,11,10 -> M0..M3 (R2)
   always_comb begin
      unique case ({s1, s0})
         2'b00:   y = cand[0];
         2'b01:   y = cand[1];
         2'b11:   y = cand[2];
         default: y = cand[3];
      endcase
   end
endmodule

// File: rtl/xpt_ctrl_cond.sv
`timescale 1ns/1ps
module xpt_ctrl_cond
   import xpt_cell_pkg::*;
(
   input  logic     gclk,
   input  logic     rclk,
   input  logic     clk_src,
   input  logic     clk_inv,
   input  logic     gce,
   input  logic     rce,
   input  logic     ce_src,
   input  logic     ce_inv,
   input  logic     roe,
   input  logic     oe_inv,
   input  oe_mode_e oe_mode,
   output logic     eclk,
   output logic     ece,
   output logic     oe_req
);
   assign eclk = (clk_src ? rclk : gclk) ^ clk_inv;
   assign ece  = (ce_src  ? rce  : gce ) ^ ce_inv;

   always_comb begin
      unique case (oe_mode)
         OE_OFF:  oe_req = 1'b0;
         OE_PIN:  oe_req = roe ^ oe_inv;
         default: oe_req = 1'b1;
      endcase
   end
endmodule

// File: rtl/xpt_store.sv
`timescale 1ns/1ps
module xpt_store
   import xpt_cell_pkg::*;
#(
   parameter int DW = 1
) (
   input  logic          eclk,
   input  logic          ece,
   input  logic          rst_n,
   input  st_mode_e      mode,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   logic [DW-1:0] rq, lq;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      always_ff @(posedge eclk or negedge rst_n) begin
         if (!rst_n)   rq[b] <= 1'b0;
         else if (ece) rq[b] <= d[b];
      end

      always_latch begin
         if (!rst_n)            lq[b] <= 1'b0;
         else if (eclk && ece)  lq[b] <= d[b];
      end
   end

   always_comb begin
      unique case (mode)
         ST_REG:   q = rq;
         ST_LATCH: q = lq;
         default:  q = d;
      endcase
   end

   logic is_reg;
   assign is_reg = (mode == ST_REG);

   assert_reg_capture_R4: assert property (@(posedge eclk) disable iff (!rst_n)
      (is_reg && ece) |=> (q == $past(d)));

   assert_hold_disabled_R5: assert property (@(posedge eclk) disable iff (!rst_n)
      (is_reg && !ece) |=> $stable(q));
endmodule

// File: rtl/xpt_pin_cell.sv
`timescale 1ns/1ps
module xpt_pin_cell
   import xpt_cell_pkg::*;
#(
   parameter int DW = 1
) (
   input  logic               gclk,
   input  logic               gce,
   input  logic               rst_n,
   input  logic               init_hold,
   input  logic [CFG_W-1:0]   cfg,
   input  logic [NSRC*DW-1:0] m_in,
   input  logic               sel_a,
   input  logic               sel_b,
   input  logic               rclk,
   input  logic               rce,
   input  logic               roe,
   input  logic [DW-1:0]      pin_in,
   output logic [DW-1:0]      pin_out,
   output logic               pin_oe,
   output logic [DW-1:0]      nbr_out,
   output logic [DW-1:0]      pool_out
);
   localparam int MW = NSRC * DW;

   if (DW < 1) begin : g_bad_dw
      $error("xpt_pin_cell: DW must be at least 1");
   end
   if ($bits(cell_cfg_t) != CFG_W) begin : g_bad_cfg
      $error("xpt_pin_cell: configuration layout width mismatch");
   end

   cell_cfg_t     c;
   logic [DW-1:0] mux_y, store_d, store_q, path_val;
   logic          eclk, ece, oe_req;

   assign c = cell_cfg_t'(cfg);

   xpt_sel_mux #(.DW(DW)) u_mux (
      .m_in   (m_in[MW-1:0]),
      .sel_a  (sel_a),
      .sel_b  (sel_b),
      .s0_src (c.s0_src),
      .s1_src (c.s1_src),
      .s0_inv (c.s0_inv),
      .s1_inv (c.s1_inv),
      .y      (mux_y)
   );

   xpt_ctrl_cond u_ctrl (
      .gclk    (gclk),
      .rclk    (rclk),
      .clk_src (c.clk_src),
      .clk_inv (c.clk_inv),
      .gce     (gce),
      .rce     (rce),
      .ce_src  (c.ce_src),
      .ce_inv  (c.ce_inv),
      .roe     (roe),
      .oe_inv  (c.oe_inv),
      .oe_mode (c.oe),
      .eclk    (eclk),
      .ece     (ece),
      .oe_req  (oe_req)
   );

   // storage sits on the pin side (path A) or the pool side (path B)
   assign store_d = c.path_b ? pin_in : mux_y;

   xpt_store #(.DW(DW)) u_store (
      .eclk  (eclk),
      .ece   (ece),
      .rst_n (rst_n),
      .mode  (c.st),
      .d     (store_d),
      .q     (store_q)
   );

   assign path_val = c.path_b ? mux_y : store_q;
   assign pin_out  = c.fix_en ? {DW{c.fix_val}} : (path_val ^ {DW{c.out_inv}});
   assign pin_oe   = !init_hold && (c.fix_en || oe_req);
   assign nbr_out  = mux_y;
   assign pool_out = c.path_b ? store_q : pin_in;

   assert_fixed_level_R9: assert property (@(posedge gclk) disable iff (!rst_n)
      (c.fix_en && !init_hold) |-> (pin_out == {DW{c.fix_val}} && pin_oe));

   assert_init_tristate_R12: assert property (@(posedge gclk) disable iff (!rst_n)
      init_hold |-> !pin_oe);

   assert_bypass_flow_R7: assert property (@(posedge gclk) disable iff (!rst_n)
      (!c.fix_en && !c.path_b && (c.st == ST_THRU || c.st == ST_THRU_ALT))
      |-> (pin_out == (nbr_out ^ {DW{c.out_inv}})));

   assert_pathb_drive_R8: assert property (@(posedge gclk) disable iff (!rst_n)
      (!c.fix_en && c.path_b) |-> (pin_out == (nbr_out ^ {DW{c.out_inv}})));
endmodule

// File: tb/tb_xpt_pin_cell.sv
`timescale 1ns/1ps
module tb_xpt_pin_cell;
   localparam int DW = 1;

   logic            clk = 1'b0;
   logic            gce = 1'b0, rst_n = 1'b0, init_hold = 1'b0;
   logic [16:0]     cfg = '0;
   logic [4*DW-1:0] m_in = '0;
   logic            sel_a = 1'b0, sel_b = 1'b0, rclk = 1'b0, rce = 1'b0, roe = 1'b0;
   logic [DW-1:0]   pin_in = '0;
   logic [DW-1:0]   pin_out, nbr_out, pool_out;
   logic            pin_oe;

   always #2 clk = ~clk;   // 250 MHz

   xpt_pin_cell #(.DW(DW)) dut (
      .gclk(clk), .gce(gce), .rst_n(rst_n), .init_hold(init_hold), .cfg(cfg),
      .m_in(m_in), .sel_a(sel_a), .sel_b(sel_b), .rclk(rclk), .rce(rce),
      .roe(roe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .nbr_out(nbr_out), .pool_out(pool_out)
   );

   integer vecs = 0, bad = 0;
   logic [31:0] rnd = 32'h1badf00d;

   // behavioural reference, built from the requirements
   logic          m_s0, m_s1, m_eclk, m_ce;
   logic [DW-1:0] m_mux, m_d, m_reg, m_lat;

   always @* begin
      m_s0 = (cfg[0] ? sel_b : sel_a) ^ cfg[2];
      m_s1 = (cfg[1] ? sel_a : sel_b) ^ cfg[3];
      if      (!m_s1 && !m_s0) m_mux = m_in[0*DW +: DW];
      else if (!m_s1 &&  m_s0) m_mux = m_in[1*DW +: DW];
      else if ( m_s1 &&  m_s0) m_mux = m_in[2*DW +: DW];
      else                     m_mux = m_in[3*DW +: DW];
      m_d    = cfg[13] ? pin_in : m_mux;
      m_eclk = (cfg[4] ? rclk : clk) ^ cfg[5];
      m_ce   = (cfg[6] ? rce : gce) ^ cfg[7];
   end

   always @(posedge m_eclk or negedge rst_n)
      if (!rst_n)    m_reg <= '0;
      else if (m_ce) m_reg <= m_d;

   always @* begin
      if (!rst_n)                m_lat = '0;
      else if (m_eclk && m_ce)   m_lat = m_d;
   end

   // R1 layout: {out_inv,fix_val,fix_en,path_b,st[1:0],oe_inv,oe[1:0],ce_inv,ce_src,clk_inv,clk_src,s1_inv,s0_inv,s1_src,s0_src}
   function automatic logic [16:0] mkcfg(
      input logic s0s, s1s, s0i, s1i, cks, cki, ces, cei,
      input logic [1:0] oe, input logic oei, input logic [1:0] st,
      input logic pb, fe, fv, oi);
      return {oi, fv, fe, pb, st, oei, oe, cei, ces, cki, cks, s1i, s0i, s1s, s0s};
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vecs++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cycle(input string ptag, input string ktag, input bit release_rst);
      logic [DW-1:0] q, val, e_pin, e_pool;
      logic          e_oe;
      @(negedge clk);
      #0.2;
      unique case (cfg[12:11])
         2'd1:    q = m_reg;
         2'd2:    q = m_lat;
         default: q = m_d;
      endcase
      val    = cfg[13] ? m_mux : q;
      e_pin  = cfg[14] ? {DW{cfg[15]}} : (val ^ {DW{cfg[16]}});
      e_pool = cfg[13] ? q : pin_in;
      e_oe   = !init_hold && (cfg[14] || cfg[9:8] == 2'd1 || cfg[9:8] == 2'd3 ||
                              (cfg[9:8] == 2'd2 && (roe ^ cfg[10])));
      chk(rst_n ? ptag : "R13 pin in reset", pin_out, e_pin);
      chk(rst_n ? ktag : "R13 pool in reset", pool_out, e_pool);
      chk("R2 R3 R14 nbr", nbr_out, m_mux);
      chk("R11 R12 oe", pin_oe, e_oe);
      #0.2;
      rnd       = rnd ^ (rnd << 13);
      rnd       = rnd ^ (rnd >> 17);
      rnd       = rnd ^ (rnd << 5);
      m_in      = rnd[4*DW-1:0];
      sel_a     = rnd[8];
      sel_b     = rnd[9];
      gce       = rnd[10];
      rce       = rnd[11];
      roe       = rnd[12];
      pin_in    = rnd[13 +: DW];
      init_hold = (rnd[22:20] == 3'd0);
      if (release_rst) rst_n = 1'b1;
      #0.6;
      rclk = ~rclk;
   endtask

   task automatic run_phase(input logic [16:0] c, input string ptag, input string ktag, input int n);
      rst_n = 1'b0;
      cfg   = c;
      cycle(ptag, ktag, 1'b0);
      cycle(ptag, ktag, 1'b1);
      for (int i = 0; i < n; i++) cycle(ptag, ktag, 1'b0);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      // bypass, output path, default selects, OE on
      run_phase(mkcfg(0,0,0,0, 0,0,0,0, 2'd1,0, 2'd0, 0,0,0,0), "R1 R7 pin", "R8 pool", 60);
      // swapped and inverted selects, routed inverted OE
      run_phase(mkcfg(1,1,1,0, 0,0,0,0, 2'd2,1, 2'd0, 0,0,0,0), "R3 R7 pin", "R8 pool", 60);
      // register on global clock and enable
      run_phase(mkcfg(0,0,0,0, 0,0,0,0, 2'd1,0, 2'd1, 0,0,0,0), "R4 R5 pin", "R8 pool", 80);
      // register on routed clock, inverted routed enable, output invert
      run_phase(mkcfg(0,1,0,1, 1,1,1,1, 2'd3,0, 2'd1, 0,0,0,1), "R4 R5 R10 pin", "R8 pool", 80);
      // latch on inverted global clock
      run_phase(mkcfg(0,0,1,0, 0,1,0,0, 2'd2,0, 2'd2, 0,0,0,0), "R6 R5 pin", "R8 pool", 80);
      // input path, register on global clock
      run_phase(mkcfg(0,0,0,0, 0,0,0,0, 2'd1,0, 2'd1, 1,0,0,1), "R8 R10 pin", "R4 R8 pool", 80);
      // input path, latch on routed clock
      run_phase(mkcfg(1,0,0,0, 1,0,1,0, 2'd2,0, 2'd2, 1,0,0,0), "R8 pin", "R6 R8 pool", 80);
      // fixed high with OE off; fixed low with output invert set (must be ignored)
      run_phase(mkcfg(0,0,0,0, 0,0,0,0, 2'd0,0, 2'd1, 0,1,1,0), "R9 pin", "R8 pool", 40);
      run_phase(mkcfg(0,0,0,0, 0,0,0,0, 2'd0,0, 2'd2, 1,1,0,1), "R9 pin", "R8 pool", 40);
      // OE off outside fixed mode
      run_phase(mkcfg(0,0,0,0, 0,0,0,0, 2'd0,0, 2'd0, 0,0,0,0), "R11 pin", "R8 pool", 30);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule